// File: doc/BRIEF.md
# Dual-Edge Camera Word Capture

This block takes in a slow parallel camera bus that presents a new word after each rising and each falling edge of the camera's own clock. All of its logic runs on one system clock at four times the camera clock, so a camera half-period is nominally two system cycles long. No clock is derived inside the block. The camera clock is treated as an ordinary input. It is synchronized, compared with a one-cycle-delayed copy of itself to find edges, and used to phase a divide-by-two capture enable. Because the enable is phased this way, each word is taken in the second cycle of its stable window and never in the cycle where it changes.

A free-running divide-by-two of the fast clock could settle in either of two phases. Here the phase is reloaded from every detected camera edge, so the enable slot always falls one cycle after an edge. The slot then repeats every second cycle until the next edge arrives. Each captured word carries a tag that says which camera edge produced it. If a camera edge lands in the same cycle as a due slot, the phase has been lost. The block then drops that slot, raises a one-cycle flag and takes the new word in the following cycle.

Top module: `cam_ddr_capture`

## Requirements
- R1: While rst_n is low at a rising system clock edge, cap_valid, phase_err, cap_rise and cap_data are all 0 after that edge.
- R2: cam_clk and cam_data each pass through two synchronizer stages. When cam_clk is first sampled at a new level at system edge n, cap_valid is first high after system edge n+3.
- R3: A capture slot falls in the system cycle right after each detected camera edge, and in every second cycle after that until the next edge. cap_valid is high for exactly one cycle after each slot that does not coincide with an edge, so cap_valid is never high in two consecutive cycles.
- R4: When cap_valid is high after system edge m, cap_data equals the cam_data value sampled at system edge m-2.
- R5: cap_rise is 1 when the camera edge most recently detected before the slot was rising (cam_clk went 0 to 1). It is 0 when that edge was falling.
- R6: When a camera edge is detected in a slot cycle, that slot produces no capture and phase_err is high for one cycle in place of cap_valid. The next slot then falls in the cycle right after that edge.
- R7: After reset, no slot occurs, and cap_valid and phase_err stay 0, until the first cam_clk edge has been detected.
- R8: While cap_valid is low, cap_data and cap_rise hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, four times the camera clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cam_clk | input | 1 | Camera clock, sampled as data |
| cam_data | input | DW | Camera data bus, changes on both camera clock edges |
| cap_data | output | DW | Last captured camera word |
| cap_valid | output | 1 | One-cycle strobe for a new word on cap_data |
| cap_rise | output | 1 | 1 if the captured word followed a rising camera edge, 0 if falling |
| phase_err | output | 1 | One-cycle flag: a camera edge fell on a capture slot |

## Verification
The two functions that can fall in the same cycle are the edge detector and the free-running capture slot. When both are active, the block must give up the capture and raise phase_err in its place, then realign the slot. The bench causes this by stretching one camera half-period to three system cycles, and also by issuing a one-cycle glitch on cam_clk. In both cases a new edge lands on a slot that was already due. A behavioural model keeps the cycle of the last edge and the parity of the slots. On every cycle it decides whether a capture, a flag or nothing is expected, and the bench compares all four outputs against that model.

// File: rtl/cam_cap_pkg.sv
// Package: shared defaults for the dual-edge camera capture block.
// Assumes nothing beyond being compiled before the modules that import it.
package cam_cap_pkg;
    localparam int unsigned CAP_DW_DEFAULT    = 10;
    localparam int unsigned CAP_SYNC_DEFAULT  = 2;
endpackage

// File: rtl/cam_sync.sv
// Module: cam_sync
// Multi-stage synchronizer for a bundle of slow asynchronous inputs.
// Assumes the bundle changes far slower than clk, so all bits settle together.
module cam_sync #(
    parameter int unsigned W      = 11,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Purpose: first capture of the asynchronous bundle.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= d;
            end
        end else begin : g_next
            // Purpose: further resolution stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/cam_phase.sv
// Module: cam_phase
// Finds camera clock edges by XOR of the synchronized level against a
// one-cycle-delayed copy. Runs a divide-by-two slot toggle whose phase is
// reloaded on every edge, so the slot falls one cycle after each edge.
// Assumes clk runs at four times the camera clock.
module cam_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic cam_lvl,
    output logic edge_now,
    output logic slot_now,
    output logic last_rise
);
    logic lvl_dly;
    logic tog;
    logic armed;

    // Purpose: XOR of the level and its delayed copy marks an edge.
    assign edge_now = cam_lvl ^ lvl_dly;
    assign slot_now = tog & armed;

    // Purpose: delayed copy, arming, edge polarity and phase-locked toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_dly   <= 1'b0;
            tog       <= 1'b0;
            armed     <= 1'b0;
            last_rise <= 1'b0;
        end else begin
            lvl_dly <= cam_lvl;
            if (edge_now) begin
                armed     <= 1'b1;
                last_rise <= cam_lvl;
                tog       <= 1'b1;
            end else if (armed) begin
                tog <= ~tog;
            end
        end
    end
endmodule

// File: rtl/cam_capture.sv
// Module: cam_capture
// Registers the word on a clean slot. Turns a slot that meets an edge
// into a phase-loss pulse. Assumes the data it is given is already synchronized.
module cam_capture #(
    parameter int unsigned DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slot_now,
    input  logic          edge_now,
    input  logic          last_rise,
    input  logic [DW-1:0] word_in,
    output logic [DW-1:0] word_out,
    output logic          word_valid,
    output logic          word_rise,
    output logic          lost_phase
);
    logic take;

    // Purpose: a slot is clean only when no edge arrives in the same cycle.
    assign take = slot_now & ~edge_now;

    // Purpose: output registers; data and tag hold between captures.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out   <= '0;
            word_valid <= 1'b0;
            word_rise  <= 1'b0;
            lost_phase <= 1'b0;
        end else begin
            word_valid <= take;
            lost_phase <= slot_now & edge_now;
            if (take) begin
                word_out  <= word_in;
                word_rise <= last_rise;
            end
        end
    end
endmodule

// File: rtl/cam_ddr_capture.sv
// Module: cam_ddr_capture (top)
// Captures a camera bus that changes on both camera clock edges, using a
// phase-locked clock enable in a 4x system clock domain.
// Assumes cam_clk is low while rst_n is low.
module cam_ddr_capture
    import cam_cap_pkg::*;
#(
    parameter int unsigned DW     = CAP_DW_DEFAULT,
    parameter int unsigned STAGES = CAP_SYNC_DEFAULT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cam_clk,
    input  logic [DW-1:0] cam_data,
    output logic [DW-1:0] cap_data,
    output logic          cap_valid,
    output logic          cap_rise,
    output logic          phase_err
);
    localparam int unsigned BW = DW + 1;

    logic [BW-1:0] bundle_s;
    logic          edge_now;
    logic          slot_now;
    logic          last_rise;

    cam_sync #(.W(BW), .STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cam_clk, cam_data}),
        .q     (bundle_s)
    );

    cam_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .cam_lvl   (bundle_s[BW-1]),
        .edge_now  (edge_now),
        .slot_now  (slot_now),
        .last_rise (last_rise)
    );

    cam_capture #(.DW(DW)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_now   (slot_now),
        .edge_now   (edge_now),
        .last_rise  (last_rise),
        .word_in    (bundle_s[DW-1:0]),
        .word_out   (cap_data),
        .word_valid (cap_valid),
        .word_rise  (cap_rise),
        .lost_phase (phase_err)
    );
endmodule

// File: rtl/cam_ddr_capture_chk.sv
// Module: cam_ddr_capture_chk
// Port-level properties of the capture block, attached by bind.
// Assumes the synchronous active-low reset of the top.
module cam_ddr_capture_chk #(
    parameter int unsigned DW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cam_clk,
    input logic [DW-1:0] cap_data,
    input logic          cap_valid,
    input logic          cap_rise,
    input logic          phase_err
);
    logic prev_clk;
    logic seen_edge;

    // Purpose: note independently whether cam_clk has toggled since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_clk  <= 1'b0;
            seen_edge <= 1'b0;
        end else begin
            prev_clk <= cam_clk;
            if (cam_clk != prev_clk) seen_edge <= 1'b1;
        end
    end

    a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> !cap_valid);

    a_r6_err_excludes_valid: assert property (@(posedge clk) disable iff (!rst_n)
        phase_err |-> !cap_valid);

    a_r7_quiet_until_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid || phase_err) |-> seen_edge);

    a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_valid |-> ($stable(cap_data) && $stable(cap_rise)));
endmodule

bind cam_ddr_capture cam_ddr_capture_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cam_clk   (cam_clk),
    .cap_data  (cap_data),
    .cap_valid (cap_valid),
    .cap_rise  (cap_rise),
    .phase_err (phase_err)
);

// File: tb/cam_ddr_capture_tb.sv
// Bench: behavioural per-cycle model (last-edge cycle, slot parity) checked every clock.
module cam_ddr_capture_tb;
    localparam int DW  = 10;
    localparam int OFS = 4;
    localparam int HMAX = 2048;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cam_clk = 1'b0;
    logic [DW-1:0] cam_data = '0;
    logic [DW-1:0] cap_data;
    logic          cap_valid, cap_rise, phase_err;

    int checks = 0;
    int bad    = 0;
    bit done   = 0;

    int stim_c[$];
    int stim_d[$];
    int hc [HMAX];
    int hd [HMAX];

    always #10 clk = ~clk;

    cam_ddr_capture #(.DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cam_clk(cam_clk), .cam_data(cam_data),
        .cap_data(cap_data), .cap_valid(cap_valid), .cap_rise(cap_rise),
        .phase_err(phase_err)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    // one camera half-period: level lv, word w, held for n system cycles
    task automatic half(input int lv, input int w, input int n);
        for (int i = 0; i < n; i++) begin
            stim_c.push_back(lv);
            stim_d.push_back(w);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: got hang expected finish");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        int lv;
        int n;
        int last_e;
        bit armed;
        int pol_m;
        int e_v, e_err, e_rise, e_data;
        int first_edge_n, first_valid_n;
        bit any_edge;

        // stimulus plan
        half(0, 0, 6);                                  // idle, no edge (R7)
        lv = 1;
        for (int i = 0; i < 12; i++) begin half(lv, 16 + i * 7, 2); lv ^= 1; end
        half(lv, 300, 3); lv ^= 1;                      // stretched: collision (R6)
        for (int i = 0; i < 6; i++) begin half(lv, 400 + i * 13, 2); lv ^= 1; end
        for (int i = 0; i < 5; i++) begin half(lv, 600 + i * 3, 4); lv ^= 1; end
        for (int i = 0; i < 4; i++) begin half(lv, 700 + i, 2); lv ^= 1; end
        half(lv, 800, 1); lv ^= 1;                      // glitch edge (R6)
        for (int i = 0; i < 8; i++) begin half(lv, (i * 97 + 5) % 1024, 2); lv ^= 1; end
        half(lv, 1023, 10);

        // reset phase (R1)
        @(posedge clk);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R1 valid", int'(cap_valid), 0);
            chk("R1 err",   int'(phase_err), 0);
            chk("R1 rise",  int'(cap_rise), 0);
            chk("R1 data",  int'(cap_data), 0);
        end
        rst_n = 1'b1;
        for (int i = 0; i < HMAX; i++) begin hc[i] = 0; hd[i] = 0; end

        n = 0; last_e = -100; armed = 0; pol_m = 0;
        e_v = 0; e_err = 0; e_rise = 0; e_data = 0;
        first_edge_n = -1; first_valid_n = -1; any_edge = 0;

        while (stim_c.size() > 0) begin
            bit en, edg;
            @(posedge clk);
            @(negedge clk);
            // outputs now reflect the model's cycle n-1
            if (cap_valid && first_valid_n < 0) first_valid_n = n;
            chk(e_err != 0 ? "R6 valid" : (!any_edge ? "R7 valid" : "R3 valid"),
                int'(cap_valid), e_v);
            chk(e_v != 0 ? "R4 data" : "R8 data", int'(cap_data), e_data);
            chk(e_v != 0 ? "R5 rise" : "R8 rise", int'(cap_rise), e_rise);
            chk("R6 err", int'(phase_err), e_err);

            // model for cycle n
            en  = armed && (((n - last_e) % 2) == 1);
            edg = (hc[n - 1 + OFS] != hc[n - 2 + OFS]);
            e_v   = (en && !edg) ? 1 : 0;
            e_err = (en && edg) ? 1 : 0;
            if (e_v != 0) begin
                e_data = hd[n - 1 + OFS];
                e_rise = pol_m;
            end
            if (edg) begin
                last_e = n;
                armed  = 1;
                pol_m  = hc[n - 1 + OFS];
                any_edge = 1;
            end

            // drive inputs sampled at posedge n+1
            hc[n + 1 + OFS] = stim_c.pop_front();
            hd[n + 1 + OFS] = stim_d.pop_front();
            if (first_edge_n < 0 && hc[n + 1 + OFS] != hc[n + OFS]) first_edge_n = n + 1;
            cam_clk  = hc[n + 1 + OFS][0];
            cam_data = hd[n + 1 + OFS][DW-1:0];
            n++;
        end

        // R2: latency from first sampled clock change to first valid
        chk("R2 latency", first_valid_n - first_edge_n, 3);

        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule